// File: doc/BRIEF.md
# Trigger Output Selector with Hold Window

This block drives one outgoing trigger line. A software-written select code picks one of five trigger sources:

- a register-set trigger flag
- the incoming trigger pin
- the loop-back of the outgoing trigger pin
- an ADC level trigger
- a logic-analyzer trigger

The chosen level reaches the output through a single register, so edges are passed with no added filtering delay.

Each time the output takes a new level from a valid source, a hold counter starts. The output is frozen for a fixed number of cycles, `HOLD_CYCLES`, which defaults to 100000 (1 ms at 100 MHz). This freeze suppresses chatter and switching noise on the trigger line. When the hold expires, the output follows the selected source again on the next clock.

Select codes outside the five sources force the output low without arming a hold. Reset is synchronous and active-high.

Top module: `trig_out_hold_sel`

## Requirements
- R1: Select code 1 picks `flag_trig`, 2 picks `pin_in_trig`, 3 picks `pin_out_trig`, 4 picks `adc_trig` and 5 picks `la_trig`. Unselected sources have no effect on `trig_o`.
- R2: With no hold running and a valid code, the value of the selected source sampled at clock edge N appears on `trig_o` after edge N, which is one cycle of latency.
- R3: When `trig_o` changes to a new level taken from a valid source, it keeps that level for exactly `HOLD_CYCLES` clock cycles. `HOLD_CYCLES` is a parameter (default 100000).
- R4: While a hold window runs, changes on any source are ignored and `trig_o` does not change.
- R5: In the first cycle after a hold window ends, `trig_o` samples the current selected source value. If that value differs from the held level, a new hold window starts.
- R6: Select codes 0, 6 and 7 drive `trig_o` low once no hold is running, and they never start a hold window. A following valid source is therefore passed at once.
- R7: Changing the select code during a hold window neither shortens nor extends that window.
- R8: A synchronous active-high `rst` sets `trig_o` to 0 and cancels any running hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Source select code (1..5 valid, others force low) |
| flag_trig | input | 1 | Register-set trigger flag |
| pin_in_trig | input | 1 | Incoming trigger pin level (already synchronized) |
| pin_out_trig | input | 1 | Loop-back of the outgoing trigger pin |
| adc_trig | input | 1 | ADC level trigger |
| la_trig | input | 1 | Logic-analyzer trigger |
| trig_o | output | 1 | Registered, hold-protected trigger output |

## Verification
The bench uses a short hold window. Its directed cases cover the following, each paired with the fault it exposes:

- **Hold length.** A source that toggles back right after an edge must be held for exactly the window length. An off-by-one counter load shows up as the return edge one cycle early or late.
- **Re-arm on expiry.** A source that changed during the hold must be picked up on the first cycle after expiry, and that pickup must arm a fresh window. A design that forgot to re-arm would let the next toggle through early.
- **Select change mid-hold.** Switching to code 0 inside a window must not release the output early.
- **Invalid codes.** Codes 6 and 0 must drop the output without arming a hold. A design that armed one would delay the next valid rising edge.
- **Reset.** A reset in the middle of a window must cancel it.

A long randomized phase then compares every cycle against a behavioural model.

// File: rtl/tosel_pkg.sv
package tosel_pkg;

    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE     = 3'd0,
        SRC_FLAG     = 3'd1,
        SRC_PIN_IN   = 3'd2,
        SRC_PIN_OUT  = 3'd3,
        SRC_ADC      = 3'd4,
        SRC_LA       = 3'd5
    } trig_src_e;

    typedef struct packed {
        logic valid;
        logic level;
    } src_pick_t;

    function automatic logic sel_is_valid(input logic [SEL_W-1:0] code);
        return (code >= SRC_FLAG) && (code <= SRC_LA);
    endfunction

endpackage

// File: rtl/tosel_src_mux.sv
module tosel_src_mux
    import tosel_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src_vec,
    output src_pick_t          pick
);

    logic [NUM_SRC-1:0] hit;

    // One decode term per source: code i+1 picks bit i (R1)
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
        localparam logic [SEL_W-1:0] CODE = SEL_W'(i + 1);
        assign hit[i] = (sel == CODE) & src_vec[i];
    end

    always_comb begin
        pick.valid = sel_is_valid(sel);
        pick.level = pick.valid & (|hit);
    end

    always_comb begin
        AST_ONEHOT_DECODE: assert ($onehot0(hit)); // R1
    end

endmodule

// File: rtl/tosel_hold_timer.sv
module tosel_hold_timer #(
    parameter int HOLD_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic busy
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL); // R3

    AST_ARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        arm |-> !busy); // R4

endmodule

// File: rtl/tosel_out_stage.sv
module tosel_out_stage
    import tosel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_pick_t pick,
    input  logic      hold_busy,
    output logic      q,
    output logic      arm
);

    logic d;

    always_comb begin
        if (hold_busy) begin
            d   = q;
            arm = 1'b0;
        end else begin
            d   = pick.level;
            arm = pick.valid && (pick.level != q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold_busy |=> $stable(q)); // R4

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!hold_busy && pick.valid) |=> (q == $past(pick.level))); // R2

    AST_INVALID_LOW: assert property (@(posedge clk) disable iff (rst)
        (!hold_busy && !pick.valid) |=> !q); // R6

endmodule

// File: rtl/trig_out_hold_sel.sv
module trig_out_hold_sel
    import tosel_pkg::*;
#(
    parameter int HOLD_CYCLES = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             flag_trig,
    input  logic             pin_in_trig,
    input  logic             pin_out_trig,
    input  logic             adc_trig,
    input  logic             la_trig,
    output logic             trig_o
);

    // Bit i is the source picked by code i+1
    logic [NUM_SRC-1:0] src_vec;
    src_pick_t          pick;
    logic               busy;
    logic               arm;

    assign src_vec = {la_trig, adc_trig, pin_out_trig, pin_in_trig, flag_trig};

    tosel_src_mux u_mux (
        .sel     (sel),
        .src_vec (src_vec),
        .pick    (pick)
    );

    tosel_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .arm  (arm),
        .busy (busy)
    );

    tosel_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .pick      (pick),
        .hold_busy (busy),
        .q         (trig_o),
        .arm       (arm)
    );

    AST_CHANGE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (!busy && pick.valid && (pick.level != trig_o)) |=> (busy || (HOLD_CYCLES < 2))); // R3

    AST_NO_HOLD_INVALID: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pick.valid) |=> !busy); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!trig_o && !busy)); // R8

endmodule

// File: tb/sim_trig_out_hold_sel.sv
module sim_trig_out_hold_sel;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic [4:0] srcs = 5'd0;
    logic       trig_o;

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    bit    started = 1'b0;
    string cur_req = "R8";

    // Behavioural reference model
    bit ref_out   = 1'b0;
    int hold_left = 0;

    always #4 clk = ~clk;

    trig_out_hold_sel #(.HOLD_CYCLES(HOLD)) u0 (
        .clk          (clk),
        .rst          (rst),
        .sel          (sel),
        .flag_trig    (srcs[0]),
        .pin_in_trig  (srcs[1]),
        .pin_out_trig (srcs[2]),
        .adc_trig     (srcs[3]),
        .la_trig      (srcs[4]),
        .trig_o       (trig_o)
    );

    always @(posedge clk) begin
        bit v;
        bit ok;
        ok = (sel >= 3'd1) && (sel <= 3'd5);
        v  = ok ? srcs[sel - 3'd1] : 1'b0;
        if (rst) begin
            ref_out   = 1'b0;
            hold_left = 0;
        end else if (hold_left > 0) begin
            hold_left = hold_left - 1;
        end else begin
            if (ok && (v != ref_out)) hold_left = HOLD - 1;
            ref_out = v;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (trig_o !== ref_out) begin
                n_fail++;
                $display("FAIL %s model compare cyc %0d: trig_o=%b expected %b", cur_req, cyc, trig_o, ref_out);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 60000) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit exp, input string req);
        n_vec++;
        if (trig_o !== exp) begin
            n_fail++;
            $display("FAIL %s directed: trig_o=%b expected %b", req, trig_o, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        started = 1'b1;
        chk(1'b0, "R8");
        rst = 1'b0;

        // R1 / R2: each code picks only its own source
        cur_req = "R1";
        for (int c = 1; c <= 5; c++) begin
            sel  = 3'(c);
            srcs = 5'b11111 & ~(5'd1 << (c - 1));
            @(negedge clk); chk(1'b0, "R1");
            srcs = 5'd1 << (c - 1);
            @(negedge clk); chk(1'b1, "R2");
            sel = 3'd0;
            repeat (10) @(negedge clk);
            chk(1'b0, "R6");
        end

        // R4 / R5: toggles inside a window are ignored; expiry samples and re-arms
        cur_req = "R4";
        sel = 3'd1; srcs = 5'b00001;
        @(negedge clk); chk(1'b1, "R2");
        srcs = 5'b00000;
        for (int k = 0; k < HOLD - 1; k++) begin
            @(negedge clk); chk(1'b1, "R4");
        end
        @(negedge clk); chk(1'b0, "R5");
        srcs = 5'b00001;
        for (int k = 0; k < HOLD - 1; k++) begin
            @(negedge clk); chk(1'b0, "R5");
        end
        @(negedge clk); chk(1'b1, "R3");

        // R7: select change mid-window does not release early
        cur_req = "R7";
        sel = 3'd0;
        for (int k = 0; k < HOLD - 1; k++) begin
            @(negedge clk); chk(1'b1, "R7");
        end
        @(negedge clk); chk(1'b0, "R7");

        // R6: code 6 drops the line without arming a hold
        cur_req = "R6";
        sel = 3'd4; srcs = 5'b01000;
        @(negedge clk); chk(1'b1, "R2");
        repeat (10) @(negedge clk);
        sel = 3'd6;
        @(negedge clk); chk(1'b0, "R6");
        sel = 3'd4;
        @(negedge clk); chk(1'b1, "R6");

        // R8: reset inside a running window cancels it
        cur_req = "R8";
        rst = 1'b1;
        @(negedge clk); chk(1'b0, "R8");
        rst = 1'b0;
        @(negedge clk); chk(1'b1, "R8");

        // R3: randomized traffic against the model
        cur_req = "R3";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            srcs = 5'($urandom);
            if (($urandom % 16) == 0) sel = 3'($urandom % 8);
            rst = (($urandom % 700) == 0);
        end
        rst = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule